// File: doc/BRIEF.md
# Shared Transmit/Receive Descriptor Ring Controller

This block owns a table of buffer descriptors shared by the transmit and receive sides of a network MAC. Each descriptor is two 32-bit words. Word 0 carries the frame length in bits 31:16 and control/status flags in bits 15:0. Word 1 carries the buffer address. A host-programmed boundary value N splits the table. Entries 0..N-1 form the transmit ring and entries N..DEPTH-1 form the receive ring.

The controller keeps one pointer for each ring. It decides when a transmit may start and hands the descriptor to the transmit datapath through a request/done handshake. For reception, it checks that the current receive descriptor is empty, grants it to the receive datapath and writes the final length back. After each frame it advances the pointers using their wrap rules and raises interrupt source bits. The interrupt output is the OR of the source bits that the mask enables, and host writes of ones clear source bits.

The host reaches registers and descriptors through a single word-addressed port. Writes take effect at the clock edge. Read data appears one cycle after the address is presented. Address bit 8 set selects the descriptor window: word index is bits 7:1 and the word select is bit 0. With bit 8 clear, bits 2:0 pick one of the following registers:

| Index | Register |
|-------|----------|
| 0 | Control |
| 1 | Interrupt source |
| 2 | Interrupt mask |
| 3 | Boundary |
| 4 | Frame limits |

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset the control, interrupt source and interrupt mask registers read 0. The boundary reads 0x40 and the frame limits register reads 0x00400600. The irq, tx_req, rx_ready and rx_grant outputs are low.
- R2: A write of 0x80 or more to the boundary register is ignored. A smaller value is stored.
- R3: A transmit starts (tx_req rises) only when all of these hold: transmit is enabled (control bit 1), the boundary is nonzero, the current descriptor's ready flag (word 0 bit 15) is set, and its length is greater than 4. When the controller is idle, tx_req rises on the second clock edge after the descriptor write that completes these conditions.
- R4: tx_len equals the descriptor length, raised to the minimum (limits bits 31:16) when the pad flag (word 0 bit 12) is set. It is then cut to the maximum (limits bits 15:0) unless huge mode (control bit 2) is set.
- R5: After a transmit completes, the transmit pointer goes to 0 if the descriptor's wrap flag (word 0 bit 13) is set. Otherwise it increments, and becomes 0 when it reaches the boundary. A 0-to-1 write of transmit enable sets the pointer to 0.
- R6: On transmit completion, word 0 is written back with bits 15, 8, 7:4 and 3:0 cleared and all other bits kept.
- R7: rx_ready is high only when receive is enabled (control bit 0) and the boundary is below 0x80. A 0-to-1 write of receive enable sets the receive pointer to the boundary.
- R8: If the current receive descriptor's empty flag (word 0 bit 15) is clear, the frame is dropped. No grant is issued, interrupt source bit 4 is set, and the receive pointer does not move.
- R9: On receive completion, word 0 takes rx_len in bits 31:16 and has bit 15 cleared, with bits 14:0 kept. The receive pointer goes to the boundary if the wrap flag (bit 13) was set or the pointer was 127. Otherwise it increments.
- R10: A completed descriptor with flag bit 14 set raises source bit 0 (transmit) or bit 2 (receive). irq is the OR of source AND mask, one cycle after the source or mask register changes. Writing ones to the source register clears those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host word address (bit 8 selects descriptor window) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after address |
| tx_req | output | 1 | Transmit descriptor handed to datapath |
| tx_idx | output | 7 | Index of the transmit descriptor |
| tx_buf_ptr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Padded/truncated transmit length |
| tx_done | input | 1 | Transmit datapath finished the frame |
| rx_ready | output | 1 | Controller can accept a receive frame |
| rx_req | input | 1 | Receive frame arrival pulse |
| rx_grant | output | 1 | Receive descriptor handed to datapath |
| rx_idx | output | 7 | Index of the receive descriptor |
| rx_buf_ptr | output | 32 | Receive buffer address |
| rx_done | input | 1 | Receive datapath finished the frame |
| rx_len | input | 16 | Final receive length, valid with rx_done |
| irq | output | 1 | Interrupt request |

## Verification
A descriptor write lands at one edge. The sequencer issues the table read at the next edge and registers tx_req at the edge after that, so the bench checks tx_req low one cycle after the write and high one cycle later. A receive request takes three edges to a grant or to the busy source bit, and the interrupt output follows the source or mask register by one more edge. Where a result is only due within that bounded window, the bench polls for up to 12 cycles and then checks the value. All values are sampled on the falling edge, between the edges that create them. Absence checks (no start, no grant) wait out the full window before sampling.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  // descriptor word 0 flag positions
  localparam int F_RDY  = 15;
  localparam int F_IRQ  = 14;
  localparam int F_WRAP = 13;
  localparam int F_PAD  = 12;
  localparam logic [15:0] TX_CLR_MASK = 16'h81FF;
  localparam logic [15:0] RX_CLR_MASK = 16'h8000;

  // interrupt source bit positions
  localparam int SRC_W    = 5;
  localparam int SRC_TX   = 0;
  localparam int SRC_RX   = 2;
  localparam int SRC_BUSY = 4;

  // control register bits
  localparam int C_RXEN = 0;
  localparam int C_TXEN = 1;
  localparam int C_HUGE = 2;
  localparam int CTRL_W = 3;

  // register indices
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_MASK = 3'd2;
  localparam logic [2:0] REG_BND  = 3'd3;
  localparam logic [2:0] REG_LIM  = 3'd4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_TX_LOOK, SQ_TX_BUSY, SQ_RX_LOOK, SQ_RX_BUSY
  } sq_state_t;
endpackage

// File: rtl/bdr_table.sv
module bdr_table #(
  parameter int DEPTH = 128,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  // host port
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             a_word,
  input  logic [31:0]      a_wdata,
  output logic [31:0]      a_rdata,
  // sequencer port (writes word 0 only)
  input  logic [IDX_W-1:0] b_idx,
  input  logic             b_we,
  input  logic [31:0]      b_wdata,
  output logic [31:0]      b_w0,
  output logic [31:0]      b_w1
);
  logic [31:0] w0_mem [DEPTH];
  logic [31:0] w1_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we && !a_word) w0_mem[a_idx] <= a_wdata;
    if (a_we && a_word)  w1_mem[a_idx] <= a_wdata;
    if (b_we)            w0_mem[b_idx] <= b_wdata;
    a_rdata <= a_word ? w1_mem[a_idx] : w0_mem[a_idx];
    b_w0    <= w0_mem[b_idx];
    b_w1    <= w1_mem[b_idx];
  end
endmodule

// File: rtl/bdr_irq.sv
module bdr_irq #(
  parameter int SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] set,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] src,
  output logic [SRC_W-1:0] mask,
  output logic             irq
);
  logic [SRC_W-1:0] clr_bits;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      src <= (src & ~clr_bits) | set;
      if (mask_we) mask <= wdata;
      irq <= |(src & mask);
    end
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we && wdata[i] && !set[i]) |=> !src[i]);
    // R10
    src_set_chk: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> src[i]);
  end
endmodule

// File: rtl/bdr_seq.sv
module bdr_seq
  import bdr_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int BND_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             huge,
  input  logic [BND_W-1:0] bnd,
  input  logic [15:0]      min_len,
  input  logic [15:0]      max_len,
  input  logic             tx_kick,
  input  logic             tx_ptr_clr,
  input  logic             rx_ptr_load,
  // table port
  input  logic [31:0]      mem_w0,
  input  logic [31:0]      mem_w1,
  output logic [IDX_W-1:0] mem_idx,
  output logic             mem_we,
  output logic [31:0]      mem_wdata,
  // transmit handshake
  output logic             tx_req,
  output logic [IDX_W-1:0] tx_idx,
  output logic [31:0]      tx_buf,
  output logic [15:0]      tx_len,
  input  logic             tx_done,
  // receive handshake
  output logic             rx_ready,
  input  logic             rx_req,
  output logic             rx_grant,
  output logic [IDX_W-1:0] rx_idx,
  output logic [31:0]      rx_buf,
  input  logic             rx_done,
  input  logic [15:0]      rx_len,
  output logic [SRC_W-1:0] irq_set
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  sq_state_t        state;
  logic [IDX_W-1:0] tx_ptr, rx_ptr;
  logic             tx_pend, rx_pend;
  logic [31:0]      cur_w0;

  logic             rx_ok, tx_go, tx_fin, rx_fin, in_rx;
  logic [15:0]      d_len, pad_len, fin_len;
  logic [BND_W-1:0] tx_inc;
  logic [IDX_W-1:0] tx_next, rx_next;

  assign rx_ok  = rx_en && (bnd < BND_W'(DEPTH));
  assign in_rx  = (state == SQ_RX_LOOK) || (state == SQ_RX_BUSY);
  assign rx_ready = rx_ok && !rx_pend && !in_rx;

  assign tx_fin = (state == SQ_TX_BUSY) && tx_done;
  assign rx_fin = (state == SQ_RX_BUSY) && rx_done;

  // transmit start decision on the freshly read descriptor
  assign d_len   = mem_w0[31:16];
  assign tx_go   = tx_en && (bnd != '0) && mem_w0[F_RDY] && (d_len > 16'd4);
  assign pad_len = (mem_w0[F_PAD] && d_len < min_len) ? min_len : d_len;
  assign fin_len = (!huge && pad_len > max_len) ? max_len : pad_len;

  // pointer advance rules
  assign tx_inc  = {1'b0, tx_ptr} + 1'b1;
  assign tx_next = (cur_w0[F_WRAP] || tx_inc >= bnd) ? '0 : tx_inc[IDX_W-1:0];
  assign rx_next = (cur_w0[F_WRAP] || rx_ptr == LAST_IDX) ? bnd[IDX_W-1:0]
                                                        : rx_ptr + 1'b1;

  always_comb begin
    if (state == SQ_IDLE)
      mem_idx = rx_pend ? rx_ptr : tx_ptr;
    else
      mem_idx = in_rx ? rx_ptr : tx_ptr;
  end

  assign mem_we    = tx_fin || rx_fin;
  assign mem_wdata = tx_fin ? {cur_w0[31:16], cur_w0[15:0] & ~TX_CLR_MASK}
                            : {rx_len, cur_w0[15:0] & ~RX_CLR_MASK};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
    end else begin
      if (tx_kick || tx_fin)         tx_pend <= 1'b1;
      else if (state == SQ_TX_LOOK)  tx_pend <= 1'b0;
      if (rx_req && rx_ready)        rx_pend <= 1'b1;
      else if (state == SQ_RX_LOOK)  rx_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      tx_ptr   <= '0;
      rx_ptr   <= '0;
      cur_w0   <= '0;
      tx_req   <= 1'b0;
      tx_idx   <= '0;
      tx_buf   <= '0;
      tx_len   <= '0;
      rx_grant <= 1'b0;
      rx_idx   <= '0;
      rx_buf   <= '0;
      irq_set  <= '0;
    end else begin
      irq_set <= '0;
      case (state)
        SQ_IDLE: begin
          if (rx_pend)      state <= SQ_RX_LOOK;
          else if (tx_pend) state <= SQ_TX_LOOK;
        end
        SQ_TX_LOOK: begin
          if (tx_go) begin
            tx_req <= 1'b1;
            tx_idx <= tx_ptr;
            tx_buf <= mem_w1;
            tx_len <= fin_len;
            cur_w0 <= mem_w0;
            state  <= SQ_TX_BUSY;
          end else begin
            state  <= SQ_IDLE;
          end
        end
        SQ_TX_BUSY: begin
          if (tx_done) begin
            tx_req          <= 1'b0;
            irq_set[SRC_TX] <= cur_w0[F_IRQ];
            tx_ptr          <= tx_next;
            state           <= SQ_IDLE;
          end
        end
        SQ_RX_LOOK: begin
          if (mem_w0[F_RDY]) begin
            rx_grant <= 1'b1;
            rx_idx   <= rx_ptr;
            rx_buf   <= mem_w1;
            cur_w0   <= mem_w0;
            state    <= SQ_RX_BUSY;
          end else begin
            irq_set[SRC_BUSY] <= 1'b1;
            state             <= SQ_IDLE;
          end
        end
        SQ_RX_BUSY: begin
          if (rx_done) begin
            rx_grant        <= 1'b0;
            irq_set[SRC_RX] <= cur_w0[F_IRQ];
            rx_ptr          <= rx_next;
            state           <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
      if (tx_ptr_clr)  tx_ptr <= '0;
      if (rx_ptr_load) rx_ptr <= bnd[IDX_W-1:0];
    end
  end

  // R3
  no_dual_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_req && rx_grant));
  // R5
  tx_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_fin && !tx_ptr_clr) |=> (tx_ptr == '0 || tx_ptr == $past(tx_ptr) + 1'b1));
  // R9
  rx_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_fin && !rx_ptr_load) |=>
      (rx_ptr == $past(bnd[IDX_W-1:0]) || rx_ptr == $past(rx_ptr) + 1'b1));
  // R8
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    irq_set[SRC_BUSY] |-> !rx_grant);
endmodule

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl
  import bdr_pkg::*;
#(
  parameter int          NUM_DESC = 128,
  parameter logic [31:0] LIM_RST  = 32'h0040_0600,
  localparam int         IDX_W    = $clog2(NUM_DESC),
  localparam int         BND_W    = IDX_W + 1,
  localparam int         HADDR_W  = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               tx_req,
  output logic [IDX_W-1:0]   tx_idx,
  output logic [31:0]        tx_buf_ptr,
  output logic [15:0]        tx_len,
  input  logic               tx_done,
  output logic               rx_ready,
  input  logic               rx_req,
  output logic               rx_grant,
  output logic [IDX_W-1:0]   rx_idx,
  output logic [31:0]        rx_buf_ptr,
  input  logic               rx_done,
  input  logic [15:0]        rx_len,
  output logic               irq
);
  localparam logic [BND_W-1:0] BND_RST = BND_W'(NUM_DESC / 2);

  logic              desc_sel, reg_we, desc_we;
  logic [2:0]        reg_idx;
  logic [CTRL_W-1:0] ctrl_q;
  logic [BND_W-1:0]  bnd_q;
  logic [31:0]       lim_q;
  logic [SRC_W-1:0]  src, mask, irq_set;
  logic              bnd_we, bnd_ok, tx_rise, rx_rise;
  logic [31:0]       reg_rd, reg_rd_q, tab_rd;
  logic              sel_q;

  logic [IDX_W-1:0]  m_idx;
  logic              m_we;
  logic [31:0]       m_wdata, m_w0, m_w1;

  assign desc_sel = host_addr[HADDR_W-1];
  assign reg_idx  = host_addr[2:0];
  assign reg_we   = host_we && !desc_sel;
  assign desc_we  = host_we && desc_sel;
  assign bnd_we   = reg_we && (reg_idx == REG_BND);
  assign bnd_ok   = host_wdata < 32'(NUM_DESC);
  assign tx_rise  = reg_we && (reg_idx == REG_CTRL) && host_wdata[C_TXEN] && !ctrl_q[C_TXEN];
  assign rx_rise  = reg_we && (reg_idx == REG_CTRL) && host_wdata[C_RXEN] && !ctrl_q[C_RXEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      bnd_q  <= BND_RST;
      lim_q  <= LIM_RST;
    end else if (reg_we) begin
      if (reg_idx == REG_CTRL)  ctrl_q <= host_wdata[CTRL_W-1:0];
      if (bnd_we && bnd_ok)     bnd_q  <= host_wdata[BND_W-1:0];
      if (reg_idx == REG_LIM)   lim_q  <= host_wdata;
    end
  end

  always_comb begin
    case (reg_idx)
      REG_CTRL: reg_rd = 32'(ctrl_q);
      REG_SRC:  reg_rd = 32'(src);
      REG_MASK: reg_rd = 32'(mask);
      REG_BND:  reg_rd = 32'(bnd_q);
      REG_LIM:  reg_rd = lim_q;
      default:  reg_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      sel_q    <= 1'b0;
    end else begin
      reg_rd_q <= reg_rd;
      sel_q    <= desc_sel;
    end
  end

  assign host_rdata = sel_q ? tab_rd : reg_rd_q;

  bdr_table #(.DEPTH(NUM_DESC), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .a_we    (desc_we),
    .a_idx   (host_addr[IDX_W:1]),
    .a_word  (host_addr[0]),
    .a_wdata (host_wdata),
    .a_rdata (tab_rd),
    .b_idx   (m_idx),
    .b_we    (m_we),
    .b_wdata (m_wdata),
    .b_w0    (m_w0),
    .b_w1    (m_w1)
  );

  bdr_irq #(.SRC_W(SRC_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set     (irq_set),
    .clr_we  (reg_we && reg_idx == REG_SRC),
    .mask_we (reg_we && reg_idx == REG_MASK),
    .wdata   (host_wdata[SRC_W-1:0]),
    .src     (src),
    .mask    (mask),
    .irq     (irq)
  );

  bdr_seq #(.DEPTH(NUM_DESC), .IDX_W(IDX_W), .BND_W(BND_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (ctrl_q[C_TXEN]),
    .rx_en       (ctrl_q[C_RXEN]),
    .huge        (ctrl_q[C_HUGE]),
    .bnd         (bnd_q),
    .min_len     (lim_q[31:16]),
    .max_len     (lim_q[15:0]),
    .tx_kick     (desc_we || tx_rise || (bnd_we && bnd_ok)),
    .tx_ptr_clr  (tx_rise),
    .rx_ptr_load (rx_rise),
    .mem_w0      (m_w0),
    .mem_w1      (m_w1),
    .mem_idx     (m_idx),
    .mem_we      (m_we),
    .mem_wdata   (m_wdata),
    .tx_req      (tx_req),
    .tx_idx      (tx_idx),
    .tx_buf      (tx_buf_ptr),
    .tx_len      (tx_len),
    .tx_done     (tx_done),
    .rx_ready    (rx_ready),
    .rx_req      (rx_req),
    .rx_grant    (rx_grant),
    .rx_idx      (rx_idx),
    .rx_buf      (rx_buf_ptr),
    .rx_done     (rx_done),
    .rx_len      (rx_len),
    .irq_set     (irq_set)
  );

  // R2
  bnd_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (bnd_we && !bnd_ok) |=> $stable(bnd_q));
  // R7
  rx_ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (ctrl_q[C_RXEN] && bnd_q < BND_W'(NUM_DESC)));
endmodule

// File: tb/bd_ring_ctrl_bench.sv
module bd_ring_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_req, rx_ready, rx_grant, irq;
  logic [6:0]  tx_idx, rx_idx;
  logic [31:0] tx_buf_ptr, rx_buf_ptr;
  logic [15:0] tx_len;
  logic        tx_done = 1'b0, rx_req = 1'b0, rx_done = 1'b0;
  logic [15:0] rx_len = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  bd_ring_ctrl u_bd_ring_ctrl (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_req(tx_req), .tx_idx(tx_idx), .tx_buf_ptr(tx_buf_ptr), .tx_len(tx_len),
    .tx_done(tx_done), .rx_ready(rx_ready), .rx_req(rx_req), .rx_grant(rx_grant),
    .rx_idx(rx_idx), .rx_buf_ptr(rx_buf_ptr), .rx_done(rx_done), .rx_len(rx_len),
    .irq(irq)
  );

  localparam int A_CTRL = 0, A_SRC = 1, A_MASK = 2, A_BND = 3, A_LIM = 4;
  localparam logic [31:0] RDY = 32'h8000, IRQB = 32'h4000, WRAP = 32'h2000, PAD = 32'h1000;

  function automatic int dw(input int i, input int w);
    return 256 + 2 * i + w;
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a[8:0]; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); host_addr = a[8:0];
    @(negedge clk); d = host_rdata;
  endtask

  task automatic wait_tx(output bit seen);
    seen = 0;
    for (int k = 0; k < 12 && !seen; k++) begin
      @(negedge clk);
      if (tx_req) seen = 1;
    end
  endtask

  task automatic done_tx();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic rx_frame(output bit granted);
    granted = 0;
    for (int k = 0; k < 12 && !rx_ready; k++) @(negedge clk);
    @(negedge clk); rx_req = 1'b1;
    @(negedge clk); rx_req = 1'b0;
    for (int k = 0; k < 12 && !granted; k++) begin
      @(negedge clk);
      if (rx_grant) granted = 1;
    end
  endtask

  task automatic rx_finish(input logic [15:0] len);
    @(negedge clk); rx_done = 1'b1; rx_len = len;
    @(negedge clk); rx_done = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    bit seen;
    int exp_len;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_SRC, v);  chk("R1 src", v, 32'h0);
    rd(A_MASK, v); chk("R1 mask", v, 32'h0);
    rd(A_BND, v);  chk("R1 boundary", v, 32'h40);
    rd(A_LIM, v);  chk("R1 limits", v, 32'h0040_0600);
    chk("R1 outputs", {28'h0, irq, tx_req, rx_ready, rx_grant}, 32'h0);

    for (int i = 0; i < 128; i++) wr(dw(i, 0), 32'h0);

    // R2 boundary guard sweep
    for (int b = 126; b < 132; b++) begin
      wr(A_BND, 32'h40);
      wr(A_BND, b);
      rd(A_BND, v);
      chk("R2 boundary write", v, (b < 128) ? b : 32'h40);
    end
    wr(A_BND, 32'hFFFF_FFFF); rd(A_BND, v); chk("R2 large write ignored", v, 32'h40);
    wr(A_BND, 3); rd(A_BND, v); chk("R2 boundary accepted", v, 3);

    // R3 no start while transmit disabled
    wr(dw(0, 1), 32'h1000);
    wr(dw(0, 0), (32'd10 << 16) | RDY | 32'h1FF | 32'h800);
    wait_tx(seen); chk("R3 no start when disabled", seen, 0);
    wr(dw(1, 1), 32'h1100); wr(dw(1, 0), (32'd11 << 16) | RDY | IRQB);
    wr(dw(2, 1), 32'h1200); wr(dw(2, 0), (32'd12 << 16) | RDY);

    // R5 enable rise starts at entry 0
    wr(A_CTRL, 32'h2);
    wait_tx(seen); chk("R3 start seen", seen, 1);
    chk("R5 idx0", tx_idx, 0); chk("R4 len10", tx_len, 10); chk("R3 buf0", tx_buf_ptr, 32'h1000);
    done_tx();
    rd(dw(0, 0), v); chk("R6 writeback", v, (32'd10 << 16) | 32'h800);
    wait_tx(seen); chk("R5 idx1", tx_idx, 1);
    done_tx();
    rd(A_SRC, v); chk("R10 tx source", v, 32'h1);
    wait_tx(seen); chk("R5 idx2", tx_idx, 2); chk("R4 len12", tx_len, 12);
    done_tx();

    // R3 latency, R5 wrap at boundary
    wr(dw(0, 0), (32'd20 << 16) | RDY | WRAP);
    @(negedge clk); chk("R3 latency edge1", tx_req, 0);
    @(negedge clk); chk("R3 latency edge2", tx_req, 1);
    chk("R5 wrapped to 0 at boundary", tx_idx, 0);
    done_tx();
    wr(dw(1, 0), (32'd9 << 16) | RDY);
    wait_tx(seen); chk("R5 wrap flag returns to 0", seen, 0);
    wr(dw(0, 0), (32'd7 << 16) | RDY);
    wait_tx(seen); chk("R5 idx0 again", tx_idx, 0);
    done_tx();
    wait_tx(seen); chk("R5 increment to 1", tx_idx, 1); chk("R4 len9", tx_len, 9);
    done_tx();
    wr(dw(2, 0), (32'd4 << 16) | RDY);
    wait_tx(seen); chk("R3 length 4 not started", seen, 0);
    wr(dw(2, 0), (32'd5 << 16) | RDY);
    wait_tx(seen); chk("R3 length 5 started", tx_idx, 2);
    done_tx();
    wr(A_BND, 0);
    wr(dw(0, 0), (32'd8 << 16) | RDY);
    wait_tx(seen); chk("R3 zero boundary blocks", seen, 0);
    wr(A_BND, 1);
    wait_tx(seen); chk("R3 start after boundary set", seen, 1);
    done_tx();

    // R4 length sweep: min 16, max 32
    wr(A_LIM, (32'd16 << 16) | 32'd32);
    for (int h = 0; h < 2; h++) begin
      wr(A_CTRL, 32'h2 | (h << 2));
      for (int p = 0; p < 2; p++) begin
        for (int len = 5; len <= 40; len++) begin
          wr(dw(0, 1), 32'h2000 + len);
          wr(dw(0, 0), (len << 16) | RDY | (p ? PAD : 32'h0));
          wait_tx(seen);
          exp_len = len;
          if (p == 1 && exp_len < 16) exp_len = 16;
          if (h == 0 && exp_len > 32) exp_len = 32;
          chk("R4 tx_len sweep", tx_len, exp_len);
          chk("R3 buffer sweep", tx_buf_ptr, 32'h2000 + len);
          done_tx();
        end
      end
    end

    // R10 mask and clear
    @(negedge clk); chk("R10 irq masked", irq, 0);
    wr(A_MASK, 1); @(negedge clk); chk("R10 irq unmasked", irq, 1);
    wr(A_SRC, 1); rd(A_SRC, v); chk("R10 w1c source", v, 0);
    @(negedge clk); chk("R10 irq after clear", irq, 0);

    // R7 receive gating
    wr(A_CTRL, 0);
    @(negedge clk); chk("R7 rx_ready disabled", rx_ready, 0);
    wr(A_BND, 120);
    for (int i = 120; i < 128; i++) begin
      wr(dw(i, 1), 32'h8000 + i);
      wr(dw(i, 0), RDY | ((i == 121) ? IRQB : 32'h0) | 32'h1);
    end
    wr(A_CTRL, 1);
    @(negedge clk); chk("R7 rx_ready enabled", rx_ready, 1);

    // R9 walk 120..127 and back to boundary
    for (int k = 0; k < 9; k++) begin
      if (k == 8) wr(dw(120, 0), RDY);
      rx_frame(seen);
      chk("R9 grant", seen, 1);
      chk("R9 rx idx", rx_idx, 120 + (k % 8));
      chk("R9 rx buf", rx_buf_ptr, 32'h8000 + 120 + (k % 8));
      rx_finish(16'(60 + k));
      if (k == 0) begin
        rd(dw(120, 0), v); chk("R9 rx writeback", v, (32'd60 << 16) | 32'h1);
      end
      if (k == 1) begin
        rd(A_SRC, v); chk("R10 rx source", v, 32'h4);
      end
    end
    wr(dw(121, 0), RDY | WRAP);
    rx_frame(seen); chk("R9 idx121", rx_idx, 121);
    rx_finish(16'd70);
    rx_frame(seen); chk("R8 full ring no grant", seen, 0);
    rd(A_SRC, v); chk("R8 busy source", v & 32'h10, 32'h10);
    wr(dw(120, 0), RDY);
    rx_frame(seen); chk("R8 pointer kept", rx_idx, 120);
    rx_finish(16'd71);

    // R7 enable rise loads the boundary
    wr(A_CTRL, 0);
    wr(A_BND, 100);
    wr(dw(100, 1), 32'h9000); wr(dw(100, 0), RDY);
    wr(A_CTRL, 1);
    rx_frame(seen); chk("R7 rx pointer at boundary", rx_idx, 100);
    rx_finish(16'd64);

    report();
  end
endmodule